// File: doc/BRIEF.md
# Cycle Counter with Control Register

This block is a free-running 32-bit cycle counter for performance monitoring. A control register sits beside it. Software reaches both registers over a small register bus. Through the control register, software starts and stops the counter, clears it, and chooses how fast it runs: one count per clock, or one count per 64 clocks. The counter can be read at any time, and it can be loaded with a new value whether it is running or stopped.

The top byte of the control register carries an identification code. That code is taken from a static input while reset is held. Only a few low control bits can be changed by software. The clear bit acts when it is written and is never stored.

Address 0 selects the control register and address 1 selects the counter. A read request is answered on the cycle after it is made. That answer shows the register as it was before the clock edge that accepted the request. A write takes effect at the clock edge that accepts it.

Top module: `pm_cycle_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the control register is loaded with `{id_i[31:24], 24'h0}` and the counter with 0.
- R2: While control bit 0 (run) is 0 and no clear or counter write is made, the counter keeps its value.
- R3: While control bit 0 is 1 and control bit 3 (slow rate) is 0, the counter increases by 1 at every clock edge.
- R4: While control bits 0 and 3 are both 1, the counter increases by 1 on every 64th enabled clock edge. A 6-bit prescaler produces this rate. The prescaler is cleared by every counter write and every clear, and it advances only while bit 0 is 1.
- R5: A control write with bit 2 set makes the counter 0 at that edge. Bit 2 always reads back as 0.
- R6: A control write changes only bits 0, 3, 4 and 5 (mask 0x39). Every other control bit keeps its value.
- R7: A write to address 1 loads the counter with the written data, whether bit 0 is set or clear. This load takes precedence over counting at that edge.
- R8: The counter wraps from 0xFFFFFFFF to 0.
- R9: A read request at address 0 or 1 returns that register in `rd_data`, with `rd_valid` high, one cycle later. The value returned is the one held before the accepting edge.
- R10: A control write that sets bit 2 and also sets new run or rate bits clears the counter first. Counting then continues from 0 under the new settings, starting at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| id_i | input | 32 | Static identification word; its top byte is loaded into the control register while reset is held |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control register, 1 = counter |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | High for one cycle when `rd_data` carries a read response |
| rd_data | output | 32 | Read response |

## Verification
The slow rate is the hardest case to reach from the ports. The counter only moves after 64 enabled edges, and the prescaler phase cannot be seen from outside. The stimulus handles this in three steps. First it loads the counter, which zeroes the prescaler. Next it enables the slow rate. Then it waits exactly 63 idle cycles and makes two back-to-back reads, which must show the value just before and just after the step. The same sequence is repeated with a counter write made while the counter is running, to show that the write restarts the prescaler. A write of all ones to the control register, and a write that clears and enables at once, cover the mask, the unstored clear bit and the clear-first ordering.

// File: rtl/pm_cycle_counter.sv
module pm_cycle_counter #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8,
  parameter int PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] id_i,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [DATA_W-1:0] WMASK  = DATA_W'(32'h39);
  localparam int                B_RUN  = 0;
  localparam int                B_CLR  = 2;
  localparam int                B_SLOW = 3;

  logic [DATA_W-1:0] ctrl_q, cnt_q;
  logic [PRE_W-1:0]  pre_q;

  wire wr_ctl = bus_valid & bus_write & ~bus_addr;
  wire wr_cnt = bus_valid & bus_write &  bus_addr;
  wire wr_clr = wr_ctl & bus_wdata[B_CLR];
  wire run    = ctrl_q[B_RUN];
  wire tick   = run & (~ctrl_q[B_SLOW] | (&pre_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= {id_i[DATA_W-1 -: ID_W], {(DATA_W-ID_W){1'b0}}};
      cnt_q  <= '0;
      pre_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (wr_ctl) ctrl_q <= (ctrl_q & ~WMASK) | (bus_wdata & WMASK);
      if (wr_clr) begin
        cnt_q <= '0;
        pre_q <= '0;
      end else if (wr_cnt) begin
        cnt_q <= bus_wdata;
        pre_q <= '0;
      end else if (run) begin
        pre_q <= pre_q + PRE_W'(1);
        if (tick) cnt_q <= cnt_q + DATA_W'(1);
      end
      rd_valid <= bus_valid & ~bus_write;
      if (bus_valid & ~bus_write) rd_data <= bus_addr ? cnt_q : ctrl_q;
    end
  end

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_clr && !wr_cnt) |=> $stable(cnt_q));
  // R3
  fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ctrl_q[B_SLOW] && !wr_clr && !wr_cnt) |=> cnt_q == $past(cnt_q) + DATA_W'(1));
  // R4
  slow_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctrl_q[B_SLOW] && !wr_clr && !wr_cnt && !(&pre_q)) |=> $stable(cnt_q));
  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (cnt_q == '0 && !ctrl_q[B_CLR]));
  // R6
  masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ctrl_q & ~WMASK) == ($past(ctrl_q) & ~WMASK));
  // R7
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !wr_clr) |=> cnt_q == $past(bus_wdata));
endmodule

// File: tb/pm_cycle_counter_tb.sv
module pm_cycle_counter_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] id_i = 32'hA5C3_1177;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  pm_cycle_counter dut_i (
    .clk(clk), .rst_n(rst_n), .id_i(id_i), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // {write, addr, wdata, expected read}
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'h0,         32'hA500_0000}, // R1 control reset
    {1'b0, 1'b1, 32'h0,         32'h0},         // R1 counter reset
    {1'b1, 1'b1, 32'h1234,      32'h0},         // R7 load while stopped
    {1'b0, 1'b1, 32'h0,         32'h1234},      // R7
    {1'b0, 1'b1, 32'h0,         32'h1234},      // R2 hold
    {1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0},         // R5 R6 all ones
    {1'b0, 1'b0, 32'h0,         32'hA500_0039}, // R6 R5
    {1'b0, 1'b1, 32'h0,         32'h0},         // R5 cleared
    {1'b1, 1'b0, 32'h0,         32'h0},         // R6 stop
    {1'b0, 1'b0, 32'h0,         32'hA500_0000}, // R6 id byte kept
    {1'b1, 1'b1, 32'hFFFF_FFFE, 32'h0},         // R7
    {1'b1, 1'b0, 32'h1,         32'h0},         // R3 run fast
    {1'b0, 1'b1, 32'h0,         32'hFFFF_FFFE}, // R3
    {1'b0, 1'b1, 32'h0,         32'hFFFF_FFFF}, // R3
    {1'b0, 1'b1, 32'h0,         32'h0},         // R8 wrap
    {1'b1, 1'b0, 32'h5,         32'h0},         // R10 clear+run
    {1'b0, 1'b1, 32'h0,         32'h0},         // R10
    {1'b0, 1'b1, 32'h0,         32'h1}          // R10
  };
  localparam int VREQ [NV] = '{1,1,7,7,2,5,6,5,6,6,7,3,3,3,8,10,10,10};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [31:0] d, output logic v);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R9", {31'b0, rd_valid}, 32'h0);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][65]) bus_wr(VEC[i][64], VEC[i][63:32]);
      else begin
        bus_rd(VEC[i][64], d, v);
        check($sformatf("R%0d", VREQ[i]), d, VEC[i][31:0]);
        check("R9", {31'b0, v}, 32'h1);
      end
    end
    // R4: slow rate from a zeroed prescaler
    bus_wr(1'b0, 32'h0);
    bus_wr(1'b1, 32'h0);
    bus_wr(1'b0, 32'h9);
    repeat (63) @(negedge clk);
    check("R9", {31'b0, rd_valid}, 32'h0);
    bus_rd(1'b1, d, v); check("R4", d, 32'd0);
    bus_rd(1'b1, d, v); check("R4", d, 32'd1);
    // R4: a counter write while running restarts the prescaler
    bus_wr(1'b1, 32'd50);
    repeat (63) @(negedge clk);
    bus_rd(1'b1, d, v); check("R4", d, 32'd50);
    bus_rd(1'b1, d, v); check("R4", d, 32'd51);
    bus_rd(1'b0, d, v); check("R6", d, 32'hA500_0009);
    // R1: reset mid-run with a new identification word
    id_i = 32'h3C00_00FF;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    bus_rd(1'b0, d, v); check("R1", d, 32'h3C00_0000);
    bus_rd(1'b1, d, v); check("R1", d, 32'h0);
    repeat (5) @(negedge clk);
    bus_rd(1'b1, d, v); check("R2", d, 32'h0);
    finish_run();
  end
endmodule